// File: doc/BRIEF.md
# PWM Period Time Base with Synchronisation

This block is the shared time base for a group of PWM generators. A 16-bit counter climbs from zero to an active period value, wraps to zero and climbs again, so one PWM cycle lasts period + 1 clocks. Software writes a period into a buffer register. The value reaches the active period either at once or at the next cycle boundary, which lets the period change without a torn cycle.

An external or internal sync event can restart the count early. This keeps several time bases aligned. The block emits a one-clock sync pulse at every cycle boundary, whether the boundary comes from a natural wrap or from a sync restart. A compare register defines a special event: when the count equals the compare value, a sticky status flag is raised. That flag drives an interrupt when its enable bit is set.

Software reaches the block through a small register port. Writes are single-cycle strobes and reads are combinational. An idle input can freeze the count.

Top module: `pwm_period_timer`

## Requirements
- R1: With the run bit at 0 the counter is cleared and held at 0. With run at 1, each advancing clock adds one, and a count at or above the active period returns to 0 on the next advancing clock, giving cycles of period + 1 clocks.
- R2: When the idle-halt bit is 1 and the idle input is high, the counter holds its value. When idle-halt is 0, idle has no effect.
- R3: A period write always updates the buffer. It also loads the active period in the same cycle when the fast-load bit is 1 or when run is 0. Otherwise the active period takes the buffer value at the next cycle boundary.
- R4: A cycle boundary (a wrap or a sync restart) produces a one-clock pulse on the sync output, in the clock where the count reads 0. The pulse level is 1, or 0 when the sync-invert bit is set. With the sync-out enable bit at 0 the output stays at its inactive level, which is 0, or 1 when sync-invert is set.
- R5: With sync-in enabled and the block running, a transition of the selected source into its active level (high, or low when sync-invert is set) passes a two-flop synchroniser. The counter then reads 0 after the third rising clock edge that samples the new level. A level held for many clocks restarts the count only once. With sync-in disabled, the source is ignored.
- R6: The source select chooses the sync source: code 000 selects the sync pin, code 010 trigger A and code 011 trigger B. Every other code selects nothing, and no restart ever occurs.
- R7: When an advancing clock sees the count equal to the compare value, the event flag is set. Writing the control register with bit 2 at 0 clears it, unless a match sets it in the same clock. Writing bit 2 as 1 does not set it. The interrupt output is high exactly when the flag and the interrupt-enable bit are both 1.
- R8: While run is 1, control writes leave sync-invert, sync-out enable, sync-in enable and source select unchanged. The other control bits are still written.
- R9: Register map: address 0 is control, address 1 is the period buffer, address 2 is compare, and address 3 is the read-only counter. The control bits are run [0], idle-halt [1], event flag [2], interrupt enable [3], fast-load [4], sync-invert [5], sync-out enable [6], sync-in enable [7] and source select [10:8]; the other bits read 0. Reset clears every register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busWe | input | 1 | Register write strobe |
| busAddr | input | 2 | Register address |
| busWdata | input | 16 | Write data |
| busRdata | output | 16 | Read data for busAddr |
| idle | input | 1 | Idle request |
| syncPin | input | 1 | External sync input |
| trigA | input | 1 | Internal trigger source A |
| trigB | input | 1 | Internal trigger source B |
| syncOut | output | 1 | Sync pulse output |
| evtIrq | output | 1 | Special event interrupt |

## Verification
On every cycle the assertions check the following rules: a stopped counter reads zero, idle-halt freezes the count, the sync pulse coincides with a zero count, a disabled sync output sits at its inactive level, the event flag survives until a control write, and the locked sync fields do not change under a write while running. Only the bench scenarios can show the other behaviours. These are the exact cycle in which a buffered period takes effect, the synchroniser latency and the single restart per transition, the decoding of the source codes including the reserved ones, and the wrap timing for different period values.

// File: rtl/ptmr_pkg.sv
package ptmr_pkg;
  localparam int ADDR_W = 2;
  localparam logic [ADDR_W-1:0] ADDR_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_PER  = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_CMP  = 2'd2;
  localparam logic [ADDR_W-1:0] ADDR_CNT  = 2'd3;
  localparam int CTRL_W = 11;

  localparam logic [2:0] SRC_PIN  = 3'b000;
  localparam logic [2:0] SRC_TRGA = 3'b010;
  localparam logic [2:0] SRC_TRGB = 3'b011;

  typedef struct packed {
    logic [2:0] syncSel;
    logic       syncInEn;
    logic       syncOutEn;
    logic       syncInv;
    logic       fastLoad;
    logic       irqEn;
    logic       evtFlag;
    logic       idleHalt;
    logic       run;
  } ctrl_t;

  typedef struct packed {
    logic hold;
    logic advance;
    logic restart;
    logic perWrite;
    logic perDirect;
    logic copyOnWrap;
    logic cmpWrite;
  } strobe_t;
endpackage

// File: rtl/ptmr_ctrl.sv
module ptmr_ctrl
  import ptmr_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  input  logic              idle,
  input  logic              syncPin,
  input  logic              trigA,
  input  logic              trigB,
  input  logic              cntAtCmp,
  input  logic              boundary,
  output ctrl_t             ctrlQ,
  output strobe_t           strobe,
  output logic              syncPulse
);
  localparam int PIPE_W = SYNC_STAGES + 1;

  logic              ctrlWr;
  logic              srcRaw;
  logic              srcValid;
  logic              srcActive;
  logic [PIPE_W-1:0] syncPipe;
  logic              syncEdge;
  logic              evtHit;

  assign ctrlWr = busWe && (busAddr == ADDR_CTRL);

  always_comb begin
    srcRaw   = 1'b0;
    srcValid = 1'b0;
    case (ctrlQ.syncSel)
      SRC_PIN:  begin srcRaw = syncPin; srcValid = 1'b1; end
      SRC_TRGA: begin srcRaw = trigA;   srcValid = 1'b1; end
      SRC_TRGB: begin srcRaw = trigB;   srcValid = 1'b1; end
      default:  begin srcRaw = 1'b0;    srcValid = 1'b0; end
    endcase
    srcActive = srcValid && (srcRaw ^ ctrlQ.syncInv);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncPipe[0] <= 1'b0;
    else       syncPipe[0] <= srcActive;
  end

  for (genvar s = 1; s < PIPE_W; s++) begin : g_sync
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) syncPipe[s] <= 1'b0;
      else       syncPipe[s] <= syncPipe[s-1];
    end
  end

  assign syncEdge = syncPipe[SYNC_STAGES-1] && !syncPipe[SYNC_STAGES];

  always_comb begin
    strobe.hold       = !ctrlQ.run;
    strobe.advance    = ctrlQ.run && !(ctrlQ.idleHalt && idle);
    strobe.restart    = strobe.advance && ctrlQ.syncInEn && syncEdge;
    strobe.perWrite   = busWe && (busAddr == ADDR_PER);
    strobe.perDirect  = ctrlQ.fastLoad || !ctrlQ.run;
    strobe.copyOnWrap = !ctrlQ.fastLoad;
    strobe.cmpWrite   = busWe && (busAddr == ADDR_CMP);
  end

  assign evtHit = strobe.advance && cntAtCmp;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlQ     <= '0;
      syncPulse <= 1'b0;
    end else begin
      syncPulse <= boundary;
      if (ctrlWr) begin
        ctrlQ.run      <= busWdata[0];
        ctrlQ.idleHalt <= busWdata[1];
        ctrlQ.irqEn    <= busWdata[3];
        ctrlQ.fastLoad <= busWdata[4];
        if (!ctrlQ.run) begin
          ctrlQ.syncInv   <= busWdata[5];
          ctrlQ.syncOutEn <= busWdata[6];
          ctrlQ.syncInEn  <= busWdata[7];
          ctrlQ.syncSel   <= busWdata[10:8];
        end
      end
      if (evtHit)                       ctrlQ.evtFlag <= 1'b1;
      else if (ctrlWr && !busWdata[2])  ctrlQ.evtFlag <= 1'b0;
    end
  end
endmodule

// File: rtl/ptmr_datapath.sv
module ptmr_datapath
  import ptmr_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobe,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] cnt,
  output logic [DATA_W-1:0] bufPer,
  output logic [DATA_W-1:0] cmpVal,
  output logic              cntAtCmp,
  output logic              boundary
);
  logic [DATA_W-1:0] actPer;
  logic              atEnd;

  assign atEnd    = (cnt >= actPer);
  assign cntAtCmp = (cnt == cmpVal);
  assign boundary = strobe.advance && (strobe.restart || atEnd);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (strobe.hold) begin
      cnt <= '0;
    end else if (strobe.advance) begin
      cnt <= boundary ? '0 : cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bufPer <= '0;
      actPer <= '0;
      cmpVal <= '0;
    end else begin
      if (strobe.perWrite) bufPer <= busWdata;
      if (strobe.perWrite && strobe.perDirect) actPer <= busWdata;
      else if (boundary && strobe.copyOnWrap)  actPer <= bufPer;
      if (strobe.cmpWrite) cmpVal <= busWdata;
    end
  end
endmodule

// File: rtl/pwm_period_timer.sv
module pwm_period_timer
  import ptmr_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWe,
  input  logic [1:0]        busAddr,
  input  logic [15:0]       busWdata,
  output logic [15:0]       busRdata,
  input  logic              idle,
  input  logic              syncPin,
  input  logic              trigA,
  input  logic              trigB,
  output logic              syncOut,
  output logic              evtIrq
);
  localparam int PAD_W = DATA_W - CTRL_W;

  ctrl_t             ctrlQ;
  strobe_t           strobe;
  logic              syncPulse;
  logic              cntAtCmp;
  logic              boundary;
  logic [DATA_W-1:0] cnt;
  logic [DATA_W-1:0] bufPer;
  logic [DATA_W-1:0] cmpVal;

  ptmr_ctrl #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .busWe(busWe), .busAddr(busAddr),
    .busWdata(busWdata), .idle(idle), .syncPin(syncPin), .trigA(trigA),
    .trigB(trigB), .cntAtCmp(cntAtCmp), .boundary(boundary),
    .ctrlQ(ctrlQ), .strobe(strobe), .syncPulse(syncPulse)
  );

  ptmr_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .busWdata(busWdata),
    .cnt(cnt), .bufPer(bufPer), .cmpVal(cmpVal),
    .cntAtCmp(cntAtCmp), .boundary(boundary)
  );

  assign syncOut = ctrlQ.syncOutEn ? (syncPulse ^ ctrlQ.syncInv) : ctrlQ.syncInv;
  assign evtIrq  = ctrlQ.evtFlag && ctrlQ.irqEn;

  always_comb begin
    case (busAddr)
      ADDR_CTRL: busRdata = {{PAD_W{1'b0}}, ctrlQ};
      ADDR_PER:  busRdata = bufPer;
      ADDR_CMP:  busRdata = cmpVal;
      default:   busRdata = cnt;
    endcase
  end
endmodule

// File: rtl/ptmr_checker.sv
module ptmr_checker (
  input logic        clk,
  input logic        rstN,
  input logic        run,
  input logic        idleHalt,
  input logic        idle,
  input logic [15:0] cnt,
  input logic        syncOut,
  input logic        syncOutEn,
  input logic        syncInv,
  input logic        syncPulse,
  input logic        evtFlag,
  input logic        ctrlWr,
  input logic [5:0]  lockedBits
);
  a_r1_stopped_is_zero: assert property (@(posedge clk) disable iff (!rstN)
    !run |=> (cnt == 16'd0));

  a_r2_idle_freeze: assert property (@(posedge clk) disable iff (!rstN)
    (run && idleHalt && idle) |=> $stable(cnt));

  a_r4_pulse_at_zero: assert property (@(posedge clk) disable iff (!rstN)
    syncPulse |-> (cnt == 16'd0));

  a_r4_out_inactive: assert property (@(posedge clk) disable iff (!rstN)
    !syncOutEn |-> (syncOut == syncInv));

  a_r7_flag_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (evtFlag && !ctrlWr) |=> evtFlag);

  a_r8_locked_fields: assert property (@(posedge clk) disable iff (!rstN)
    (run && ctrlWr) |=> $stable(lockedBits));
endmodule

bind pwm_period_timer ptmr_checker u_chk (
  .clk(clk), .rstN(rstN), .run(ctrlQ.run), .idleHalt(ctrlQ.idleHalt),
  .idle(idle), .cnt(cnt), .syncOut(syncOut), .syncOutEn(ctrlQ.syncOutEn),
  .syncInv(ctrlQ.syncInv), .syncPulse(syncPulse), .evtFlag(ctrlQ.evtFlag),
  .ctrlWr(busWe && (busAddr == 2'd0)),
  .lockedBits({ctrlQ.syncSel, ctrlQ.syncInEn, ctrlQ.syncOutEn, ctrlQ.syncInv})
);

// File: tb/pwm_period_timer_bench.sv
module pwm_period_timer_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWe = 1'b0;
  logic [1:0]  busAddr = 2'd3;
  logic [15:0] busWdata = '0;
  logic [15:0] busRdata;
  logic        idle = 1'b0;
  logic        syncPin = 1'b0;
  logic        trigA = 1'b0;
  logic        trigB = 1'b0;
  logic        syncOut;
  logic        evtIrq;

  always #5 clk = ~clk;

  pwm_period_timer u_pwm_period_timer (
    .clk(clk), .rstN(rstN), .busWe(busWe), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .idle(idle),
    .syncPin(syncPin), .trigA(trigA), .trigB(trigB),
    .syncOut(syncOut), .evtIrq(evtIrq)
  );

  int total = 0;
  int bad = 0;
  int cyc = 0;
  string phase = "R9 reset";

  // reference model state
  bit          mRun, mIdleHalt, mFlag, mIrqEn, mFast, mInv, mOutEn, mInEn;
  bit [2:0]    mSel;
  int unsigned mBuf, mAct, mCmp, mCnt;
  bit          mPulse;
  bit          hist[$];

  function automatic int unsigned mRead(input logic [1:0] a);
    case (a)
      2'd0: return {mSel, mInEn, mOutEn, mInv, mFast, mIrqEn, mFlag, mIdleHalt, mRun};
      2'd1: return mBuf;
      2'd2: return mCmp;
      default: return mCnt;
    endcase
  endfunction

  task automatic modelReset();
    {mRun, mIdleHalt, mFlag, mIrqEn, mFast, mInv, mOutEn, mInEn} = '0;
    mSel = 0; mBuf = 0; mAct = 0; mCmp = 0; mCnt = 0; mPulse = 0;
    hist = '{0, 0, 0};
  endtask

  task automatic modelStep();
    bit src, adv, rst, wrap, hit, oldRun;
    int unsigned oldBuf;
    case (mSel)
      3'b000: src = syncPin ^ mInv;
      3'b010: src = trigA ^ mInv;
      3'b011: src = trigB ^ mInv;
      default: src = 0;
    endcase
    adv    = mRun && !(mIdleHalt && idle);
    rst    = adv && mInEn && hist[1] && !hist[2];
    wrap   = adv && (rst || mCnt >= mAct);
    hit    = adv && (mCnt == mCmp);
    oldRun = mRun;
    oldBuf = mBuf;
    mPulse = wrap;
    if (!mRun) mCnt = 0;
    else if (adv) mCnt = wrap ? 0 : (mCnt + 1) % 65536;
    if (busWe && busAddr == 2'd1) begin
      mBuf = busWdata;
      if (mFast || !mRun) mAct = busWdata;
      else if (wrap) mAct = oldBuf;
    end else if (wrap && !mFast) mAct = oldBuf;
    if (busWe && busAddr == 2'd2) mCmp = busWdata;
    if (hit) mFlag = 1;
    else if (busWe && busAddr == 2'd0 && !busWdata[2]) mFlag = 0;
    if (busWe && busAddr == 2'd0) begin
      mRun = busWdata[0]; mIdleHalt = busWdata[1];
      mIrqEn = busWdata[3]; mFast = busWdata[4];
      if (!oldRun) begin
        mInv = busWdata[5]; mOutEn = busWdata[6];
        mInEn = busWdata[7]; mSel = busWdata[10:8];
      end
    end
    hist.push_front(src);
    void'(hist.pop_back());
  endtask

  task automatic chk(input string what, input int unsigned act, input int unsigned exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", phase, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (!rstN) modelReset();
    else modelStep();
    if (cyc > 100000) begin
      bad++;
      $display("FAIL watchdog expired in %s", phase);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // per-cycle comparison: R1 count, R4 sync out, R7 interrupt, R9 readback
  always @(negedge clk) begin
    if (rstN) begin
      chk("readback", busRdata, mRead(busAddr));
      chk("syncOut", syncOut, mOutEn ? (mPulse ^ mInv) : mInv);
      chk("evtIrq", evtIrq, mFlag && mIrqEn);
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
    #2;
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    busWe = 1'b1; busAddr = a; busWdata = d;
    step(1);
    busWe = 1'b0; busAddr = 2'd3;
  endtask

  task automatic peek(input logic [1:0] a);
    busAddr = a; step(1); busAddr = 2'd3;
  endtask

  initial begin
    modelReset();
    step(3);
    rstN = 1'b1;
    // R9: reset state of every register
    peek(2'd0); peek(2'd1); peek(2'd2); peek(2'd3);
    chk("reset syncOut", syncOut, 0);
    chk("reset evtIrq", evtIrq, 0);

    phase = "R1 basic count period 5";
    wr(2'd1, 16'd5); wr(2'd2, 16'd3);
    wr(2'd0, 16'h0049);
    step(20);

    phase = "R7 flag clear and write-one";
    wr(2'd0, 16'h0049); step(1);
    wr(2'd2, 16'd100); wr(2'd0, 16'h0049); step(3);
    wr(2'd0, 16'h004D); peek(2'd0); step(3);
    wr(2'd2, 16'd1); step(10);

    phase = "R3 buffered period";
    wr(2'd1, 16'd2); peek(2'd1); step(15);
    wr(2'd1, 16'd9); step(2); wr(2'd1, 16'd4); step(20);

    phase = "R3 fast load";
    wr(2'd0, 16'h0059); wr(2'd1, 16'd7); step(20);
    wr(2'd1, 16'd1); step(8);

    phase = "R8 locked while running";
    wr(2'd0, 16'h07F9); peek(2'd0); step(2);
    wr(2'd0, 16'h0019); peek(2'd0); step(3);

    phase = "R2 idle halt";
    wr(2'd1, 16'd6); wr(2'd0, 16'h004B);
    idle = 1'b1; step(6); idle = 1'b0; step(5);
    wr(2'd0, 16'h0049);
    idle = 1'b1; step(6); idle = 1'b0; step(3);

    phase = "R4 output disabled inverted";
    wr(2'd0, 16'h0000); wr(2'd0, 16'h0020); wr(2'd0, 16'h0021); step(15);

    phase = "R5 sync pin restart";
    wr(2'd0, 16'h0000); wr(2'd1, 16'd20);
    syncPin = 1'b1; trigA = 1'b1; trigB = 1'b1;
    wr(2'd0, 16'h00E0); wr(2'd0, 16'h00E1); step(5);
    syncPin = 1'b0; step(2); syncPin = 1'b1; step(8);
    syncPin = 1'b0; step(1); syncPin = 1'b1; step(10);
    syncPin = 1'b0; step(12); syncPin = 1'b1; step(6);

    phase = "R5 sync in disabled";
    wr(2'd0, 16'h0000); wr(2'd0, 16'h0060); wr(2'd0, 16'h0061); step(4);
    syncPin = 1'b0; step(3); syncPin = 1'b1; step(6);

    phase = "R6 source trigger A";
    wr(2'd0, 16'h0000); wr(2'd0, 16'h02E0); wr(2'd0, 16'h02E1); step(4);
    trigA = 1'b0; step(2); trigA = 1'b1; step(3);
    syncPin = 1'b0; step(2); syncPin = 1'b1; step(8);

    phase = "R6 source trigger B";
    wr(2'd0, 16'h0000); wr(2'd0, 16'h03E0); wr(2'd0, 16'h03E1); step(4);
    trigB = 1'b0; step(2); trigB = 1'b1; step(3);
    trigA = 1'b0; step(2); trigA = 1'b1; step(8);

    phase = "R6 reserved code";
    wr(2'd0, 16'h0000); wr(2'd0, 16'h05E0); wr(2'd0, 16'h05E1); step(4);
    syncPin = 1'b0; trigA = 1'b0; trigB = 1'b0; step(3);
    syncPin = 1'b1; trigA = 1'b1; trigB = 1'b1; step(8);

    phase = "R5 active-high sync";
    wr(2'd0, 16'h0000); syncPin = 1'b0;
    wr(2'd0, 16'h00C0); wr(2'd0, 16'h00C1); step(6);
    syncPin = 1'b1; step(3); syncPin = 1'b0; step(10);

    phase = "R1 stop";
    wr(2'd0, 16'h0000); step(4);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule